// File: doc/BRIEF.md
# Write-Protection Unlock Sequence Detector

This block sits beside a byte-wide parallel memory and watches the write cycles that reach it. It decides whether each write is a command or a request to store data. A fixed series of six writes turns software write protection off. A three-write prefix turns protection on and also admits the single data write that comes right after it. While protection is on, the block blocks every other store to the array.

A write is taken on the rising edge of the write-enable pin, provided chip enable is low and output enable is high at that moment. The edge is found synchronously in the system clock domain. When the six-write unlock completes, protection drops and a busy flag is held for a parameterised write-cycle time. The block ignores all writes during that time. A deviation at any point of either series returns the matcher to idle. A separate output says when the device may drive the data bus, and it is never active while the chip is deselected.

Top module: `wprot_seq_guard`

## Requirements
- R1: After reset, prot_on is 1, busy is 0 and array_wr_en is 0.
- R2: A write is accepted only on a low-to-high transition of we_n while ce_n is 0 and oe_n is 1. A rising we_n with oe_n at 0 or ce_n at 1 causes no array write.
- R3: Six accepted writes in the order (address 5555h, data AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (5555h, 20h) clear prot_on. The flag reads 0 one clock after the sixth write is captured.
- R4: A write that does not match the expected pair sends the matcher to idle. That write is not itself taken as the first step of a new series.
- R5: Only address bits 14:0 take part in matching. Bits 16:15 have no effect.
- R6: Completing the unlock series raises busy one clock after capture. Busy stays high for exactly TWC_CYC clock cycles.
- R7: Writes accepted while busy is high are ignored. They produce no array write and do not advance the matcher.
- R8: The writes (5555h, AAh), (2AAAh, 55h), (5555h, A0h) set prot_on.
- R9: While prot_on is 1, array_wr_en pulses only for the single write that directly follows the three-write enable prefix.
- R10: While prot_on is 0, every accepted write that is not ignored by R7 pulses array_wr_en for one clock, one clock after capture. The write that completes an unlock is one of these.
- R11: data_oe is 1 only when ce_n is 0, oe_n is 0 and we_n is 1. It is never 1 while ce_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; rising edge captures a write |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 17 | Bus address |
| data | input | 8 | Bus write data |
| prot_on | output | 1 | Software write protection is active |
| busy | output | 1 | Internal write-cycle time is running |
| array_wr_en | output | 1 | One-clock pulse: the captured write may be stored in the array |
| data_oe | output | 1 | Device may drive the data bus |

## Verification
The sixth unlock write and an ordinary array store can both land on the same capture edge. This happens when protection is already off, so one write must both pulse array_wr_en and start the busy window. The bench provokes it by running a full unlock series while unprotected. It then checks that the final write produced an array pulse, that busy rose on the same edge, and that a write arriving inside the window produced neither a pulse nor a matcher step.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
   localparam int unsigned KEY_ADDR_W = 15;
   localparam logic [KEY_ADDR_W-1:0] ADR_HI = 15'h5555;
   localparam logic [KEY_ADDR_W-1:0] ADR_LO = 15'h2AAA;

   localparam logic [7:0] CODE_AA  = 8'hAA;
   localparam logic [7:0] CODE_55  = 8'h55;
   localparam logic [7:0] CODE_UNL = 8'h80;
   localparam logic [7:0] CODE_FIN = 8'h20;
   localparam logic [7:0] CODE_ENA = 8'hA0;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_K1   = 3'd1,
      ST_K2   = 3'd2,
      ST_U3   = 3'd3,
      ST_U4   = 3'd4,
      ST_U5   = 3'd5,
      ST_ARM  = 3'd6
   } seq_st_t;
endpackage

// File: rtl/wpg_strobe.sv
module wpg_strobe #(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int IN_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              stb,
   output logic [ADDR_W-1:0] s_addr,
   output logic [DATA_W-1:0] s_data
);
   localparam int BW = 3 + ADDR_W + DATA_W;
   localparam logic [BW-1:0] RST_V = {3'b111, {(BW-3){1'b0}}};

   logic [BW-1:0] raw_bus;
   logic [BW-1:0] stg_out;
   logic          ce_s, we_s, oe_s;
   logic          we_q;

   assign raw_bus = {ce_n, we_n, oe_n, addr, data};

   generate
      if (IN_STAGES == 0) begin : g_direct
         assign stg_out = raw_bus;
      end else begin : g_piped
         logic [BW-1:0] stg [IN_STAGES];
         for (genvar i = 0; i < IN_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk) begin
                  if (!rst_n) stg[i] <= RST_V;
                  else        stg[i] <= raw_bus;
               end
            end else begin : g_next
               always_ff @(posedge clk) begin
                  if (!rst_n) stg[i] <= RST_V;
                  else        stg[i] <= stg[i-1];
               end
            end
         end
         assign stg_out = stg[IN_STAGES-1];
      end
   endgenerate

   assign {ce_s, we_s, oe_s, s_addr, s_data} = stg_out;

   always_ff @(posedge clk) begin
      if (!rst_n) we_q <= 1'b1;
      else        we_q <= we_s;
   end

   assign stb = !we_q && we_s && !ce_s && oe_s;
endmodule

// File: rtl/wpg_seq_fsm.sv
module wpg_seq_fsm
   import wpg_pkg::*;
#(
   parameter int CMP_W         = 15,
   parameter int DATA_W        = 8,
   parameter bit PROT_AT_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [CMP_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              prot_on,
   output logic              unlock_done,
   output logic              arm_hit
);
   function automatic logic [CMP_W-1:0] az(input logic [KEY_ADDR_W-1:0] a);
      logic [CMP_W-1:0] v;
      v = '0;
      v[KEY_ADDR_W-1:0] = a;
      return v;
   endfunction

   function automatic logic [DATA_W-1:0] dz(input logic [7:0] c);
      logic [DATA_W-1:0] v;
      v = '0;
      v[7:0] = c;
      return v;
   endfunction

   logic hi_aa, lo_55, hi_unl, hi_ena, hi_fin;
   assign hi_aa  = (wr_addr == az(ADR_HI)) && (wr_data == dz(CODE_AA));
   assign lo_55  = (wr_addr == az(ADR_LO)) && (wr_data == dz(CODE_55));
   assign hi_unl = (wr_addr == az(ADR_HI)) && (wr_data == dz(CODE_UNL));
   assign hi_ena = (wr_addr == az(ADR_HI)) && (wr_data == dz(CODE_ENA));
   assign hi_fin = (wr_addr == az(ADR_HI)) && (wr_data == dz(CODE_FIN));

   seq_st_t st_q, st_d;
   logic    set_prot;

   always_comb begin
      st_d        = st_q;
      set_prot    = 1'b0;
      unlock_done = 1'b0;
      arm_hit     = 1'b0;
      if (wr_stb) begin
         st_d = ST_IDLE;
         unique case (st_q)
            ST_IDLE: if (hi_aa) st_d = ST_K1;
            ST_K1:   if (lo_55) st_d = ST_K2;
            ST_K2: begin
               if (hi_unl) st_d = ST_U3;
               else if (hi_ena) begin
                  st_d     = ST_ARM;
                  set_prot = 1'b1;
               end
            end
            ST_U3:   if (hi_aa) st_d = ST_U4;
            ST_U4:   if (lo_55) st_d = ST_U5;
            ST_U5:   unlock_done = hi_fin;
            ST_ARM:  arm_hit = 1'b1;
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         prot_on <= PROT_AT_RESET;
      end else begin
         st_q <= st_d;
         if (set_prot)         prot_on <= 1'b1;
         else if (unlock_done) prot_on <= 1'b0;
      end
   end
endmodule

// File: rtl/wpg_busy_timer.sv
module wpg_busy_timer #(
   parameter int TWC_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(TWC_CYC + 1);
   localparam logic [CW-1:0] LOAD_V = CW'(TWC_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (start)      cnt_q <= LOAD_V;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/wprot_seq_guard.sv
module wprot_seq_guard #(
   parameter int ADDR_W        = 17,
   parameter int DATA_W        = 8,
   parameter int CMP_W         = 15,
   parameter int TWC_CYC       = 64,
   parameter int IN_STAGES     = 0,
   parameter bit PROT_AT_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              prot_on,
   output logic              busy,
   output logic              array_wr_en,
   output logic              data_oe
);
   generate
      if (CMP_W < 15 || CMP_W > ADDR_W) begin : g_bad_cmp
         $error("CMP_W must lie between 15 and ADDR_W");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be at least 8");
      end
      if (TWC_CYC < 1) begin : g_bad_twc
         $error("TWC_CYC must be at least 1");
      end
      if (IN_STAGES < 0) begin : g_bad_stg
         $error("IN_STAGES must not be negative");
      end
   endgenerate

   logic              stb;
   logic [ADDR_W-1:0] s_addr;
   logic [DATA_W-1:0] s_data;
   logic              accept;
   logic              unlock_done;
   logic              arm_hit;
   logic              gate_pass;
   logic              arr_q;

   wpg_strobe #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IN_STAGES(IN_STAGES)
   ) u_strobe (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .data(data), .stb(stb), .s_addr(s_addr), .s_data(s_data)
   );

   generate
      if (CMP_W < ADDR_W) begin : g_hi_bits
         logic unused_addr_hi;
         assign unused_addr_hi = ^s_addr[ADDR_W-1:CMP_W];
      end
   endgenerate

   assign accept = stb && !busy;

   wpg_seq_fsm #(
      .CMP_W(CMP_W), .DATA_W(DATA_W), .PROT_AT_RESET(PROT_AT_RESET)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_stb(accept),
      .wr_addr(s_addr[CMP_W-1:0]), .wr_data(s_data),
      .prot_on(prot_on), .unlock_done(unlock_done), .arm_hit(arm_hit)
   );

   wpg_busy_timer #(
      .TWC_CYC(TWC_CYC)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .start(unlock_done), .busy(busy)
   );

   assign gate_pass = accept && (!prot_on || arm_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) arr_q <= 1'b0;
      else        arr_q <= gate_pass;
   end

   assign array_wr_en = arr_q;
   assign data_oe     = !ce_n && !oe_n && we_n;
endmodule

// File: rtl/wprot_seq_guard_chk.sv
module wprot_seq_guard_chk #(
   parameter int TWC_CYC = 64
) (
   input logic clk,
   input logic rst_n,
   input logic prot_on,
   input logic busy,
   input logic array_wr_en
);
   int unsigned blen;

   always_ff @(posedge clk) begin
      if (!rst_n)    blen <= 0;
      else if (busy) blen <= blen + 1;
      else           blen <= 0;
   end

   // R6: busy starts only together with the drop of protection
   assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $fell(prot_on) || !prot_on);

   // R3: protection never drops without starting the write-cycle time
   assert_unlock_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prot_on) |-> busy);

   // R6: busy window has the exact length
   assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> blen == TWC_CYC);

   // R7: nothing accepted while busy reaches the array
   assert_busy_no_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !array_wr_en);

   // R7: protection is frozen during the write-cycle time
   assert_busy_prot_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(prot_on));

   // R8: enabling never coincides with a running write cycle
   assert_enable_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot_on) |-> !busy);
endmodule

bind wprot_seq_guard wprot_seq_guard_chk #(.TWC_CYC(TWC_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .prot_on(prot_on), .busy(busy),
   .array_wr_en(array_wr_en)
);

// File: tb/wprot_seq_guard_tb_top.sv
`timescale 1ns/1ps
module wprot_seq_guard_tb_top;
   localparam int TWC = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [16:0] addr = '0;
   logic [7:0]  data = '0;
   logic        prot_on, busy, array_wr_en, data_oe;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wprot_seq_guard #(.TWC_CYC(TWC)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .data(data), .prot_on(prot_on), .busy(busy),
      .array_wr_en(array_wr_en), .data_oe(data_oe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [16:0] a, input logic [7:0] d,
                            input logic oe_lvl, input logic ce_lvl, output logic pulse);
      @(negedge clk);
      ce_n = ce_lvl; oe_n = oe_lvl; addr = a; data = d; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      pulse = array_wr_en;
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic wr(input logic [16:0] a, input logic [7:0] d,
                     input logic exp_arr, input string req);
      logic p;
      bus_write(a, d, 1'b1, 1'b0, p);
      chk(p == exp_arr, req, p, exp_arr);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(prot_on == 1'b1, "R1 prot", prot_on, 1);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(array_wr_en == 1'b0, "R1 arr", array_wr_en, 0);
   endtask

   task automatic t_unlock_basic();
      wr(17'h05555, 8'hAA, 0, "R3 step1");
      wr(17'h02AAA, 8'h55, 0, "R3 step2");
      wr(17'h05555, 8'h80, 0, "R3 step3");
      wr(17'h05555, 8'hAA, 0, "R3 step4");
      wr(17'h02AAA, 8'h55, 0, "R3 step5");
      wr(17'h05555, 8'h20, 0, "R3 step6");
      chk(prot_on == 1'b0, "R3 cleared", prot_on, 0);
      chk(busy == 1'b1, "R6 busy rise", busy, 1);
      repeat (TWC - 1) @(negedge clk);
      chk(busy == 1'b1, "R6 busy last cycle", busy, 1);
      @(negedge clk);
      chk(busy == 1'b0, "R6 busy end", busy, 0);
   endtask

   task automatic t_unprot_writes();
      logic p;
      wr(17'h00123, 8'h3C, 1, "R10 store");
      bus_write(17'h00124, 8'h11, 1'b0, 1'b0, p);
      chk(p == 1'b0, "R2 oe low", p, 0);
      bus_write(17'h00125, 8'h22, 1'b1, 1'b1, p);
      chk(p == 1'b0, "R2 ce high", p, 0);
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      #1;
      chk(data_oe == 1'b1, "R11 read drive", data_oe, 1);
      ce_n = 1'b1;
      #1;
      chk(data_oe == 1'b0, "R11 standby", data_oe, 0);
      ce_n = 1'b0; we_n = 1'b0;
      #1;
      chk(data_oe == 1'b0, "R11 write phase", data_oe, 0);
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic t_busy_ignore();
      wr(17'h05555, 8'hAA, 1, "R10 seq1");
      wr(17'h02AAA, 8'h55, 1, "R10 seq2");
      wr(17'h05555, 8'h80, 1, "R10 seq3");
      wr(17'h05555, 8'hAA, 1, "R10 seq4");
      wr(17'h02AAA, 8'h55, 1, "R10 seq5");
      wr(17'h05555, 8'h20, 1, "R10 final store with unlock");
      chk(busy == 1'b1, "R6 busy with store", busy, 1);
      wr(17'h00077, 8'h99, 0, "R7 store ignored");
      wr(17'h05555, 8'hAA, 0, "R7 key1 ignored");
      wr(17'h02AAA, 8'h55, 0, "R7 key2 ignored");
      chk(busy == 1'b1, "R7 still busy", busy, 1);
      wait_idle();
      wr(17'h05555, 8'hA0, 1, "R7 enable tail alone");
      chk(prot_on == 1'b0, "R7 matcher not advanced", prot_on, 0);
   endtask

   task automatic t_enable();
      wr(17'h05555, 8'hAA, 1, "R8 en1");
      wr(17'h02AAA, 8'h55, 1, "R8 en2");
      wr(17'h05555, 8'hA0, 1, "R8 en3");
      chk(prot_on == 1'b1, "R8 set", prot_on, 1);
      wr(17'h00400, 8'h5A, 1, "R9 armed store");
      wr(17'h00401, 8'h5B, 0, "R9 second store blocked");
      wr(17'h05555, 8'hA0, 0, "R9 bare enable code blocked");
   endtask

   task automatic t_mismatch();
      wr(17'h05555, 8'hAA, 0, "R4 a1");
      wr(17'h02AAA, 8'h55, 0, "R4 a2");
      wr(17'h05555, 8'h80, 0, "R4 a3");
      wr(17'h05555, 8'hAA, 0, "R4 a4");
      wr(17'h02AAB, 8'h55, 0, "R4 bad addr");
      wr(17'h02AAA, 8'h55, 0, "R4 a5");
      wr(17'h05555, 8'h20, 0, "R4 a6");
      chk(prot_on == 1'b1, "R4 broken series", prot_on, 1);
      wr(17'h05555, 8'hAA, 0, "R4 b1");
      wr(17'h02AAA, 8'h55, 0, "R4 b2");
      wr(17'h05555, 8'hAA, 0, "R4 b deviation");
      wr(17'h02AAA, 8'h55, 0, "R4 b3");
      wr(17'h05555, 8'h80, 0, "R4 b4");
      wr(17'h05555, 8'hAA, 0, "R4 b5");
      wr(17'h02AAA, 8'h55, 0, "R4 b6");
      wr(17'h05555, 8'h20, 0, "R4 b7");
      chk(prot_on == 1'b1, "R4 no restart", prot_on, 1);
      chk(busy == 1'b0, "R4 no busy", busy, 0);
   endtask

   task automatic t_upper_addr();
      wr(17'h15555, 8'hAA, 0, "R5 u1");
      wr(17'h12AAA, 8'h55, 0, "R5 u2");
      wr(17'h1D555, 8'h80, 0, "R5 u3");
      wr(17'h15555, 8'hAA, 0, "R5 u4");
      wr(17'h0AAAA, 8'h55, 0, "R5 u5");
      wr(17'h15555, 8'h20, 0, "R5 u6");
      chk(prot_on == 1'b0, "R5 unlock high bits", prot_on, 0);
      wait_idle();
      wr(17'h01555, 8'hAA, 1, "R5 bit14 differs");
      wr(17'h02AAA, 8'h55, 1, "R5 v2");
      wr(17'h05555, 8'hA0, 1, "R5 v3");
      chk(prot_on == 1'b0, "R5 low bits matter", prot_on, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_unlock_basic();
      t_unprot_writes();
      t_busy_ignore();
      t_enable();
      t_mismatch();
      t_upper_addr();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule